// File: doc/BRIEF.md
# I2C Register-Write Target

This block is a write-only two-wire bus target. It runs on a fast system clock and oversamples the serial clock and data lines, which the host drives. It finds bus START and STOP conditions and receives the first byte of each transfer: a 7-bit target address followed by a direction bit. That address is compared with a value formed from a fixed three-bit prefix and a four-bit select input.

When the address matches and the transfer is a write, the block acknowledges it. The next byte sets a register pointer. Every byte after that is acknowledged and handed to the surrounding logic as a single-cycle write strobe that carries the pointer and the data. The pointer then advances by one.

The data line is never driven high. The block only asserts a pull-low enable, which the pad turns into an open-drain output.

Top module: `i2c_reg_wr_target`

## Requirements
- R1: A START (data falling while clock is high) begins address reception from any state. A STOP (data rising while clock is high) returns the block to idle with the pull-low released.
- R2: The expected address is {3'b110, addr_sel_i}. It is received MSB first and followed by a direction bit, where 0 means write.
- R3: On a matching write address, sda_pull_o is asserted for the 9th clock pulse: from the clock fall that ends the 8th bit until the next clock fall.
- R4: The first byte after an acknowledged address is the register pointer. It is acknowledged and produces no write strobe.
- R5: Each later byte is acknowledged and produces exactly one one-cycle wr_valid_o pulse with wr_index_o = pointer and wr_data_o = byte. The pointer then increments modulo 256.
- R6: On an address mismatch the block gives no acknowledge, no pull-low and no strobe until the next START.
- R7: A matching address with direction bit 1 (read) is not acknowledged.
- R8: A repeated START in the middle of a transfer restarts address reception. The following pointer byte replaces the old pointer.
- R9: sda_pull_o stays low while the host shifts data bits, and it changes only after a clock fall, START or STOP.
- R10: Both lines pass through a two-flop synchronizer plus an edge register. The acknowledge pull-low appears on the third system-clock edge after the clock line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 4 | Low four bits of the target address |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_index_o | output | 8 | Register index of the write |
| wr_data_o | output | 8 | Data of the write |

## Verification
Several properties are checked on every cycle:
- the write strobe lasts one cycle and coincides with the start of the acknowledge pull-low;
- successive strobes within a transfer carry consecutive indices;
- the pull-low only moves after a clock fall or a bus condition;
- a STOP always releases the line.

Address decoding against the select input, refusal of reads and mismatches, pointer loading, index wrap-around, repeated START and the exact acknowledge latency are shown only by the bench's bus scenarios. There, a scoreboard compares every strobe against the writes the host issued.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_SKIP
  } phase_e;

  localparam logic [2:0] ADDR_PREFIX = 3'b110;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // conditions need clock high on both samples
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/i2c_reg_wr_target.sv
module i2c_reg_wr_target
  import i2c_wr_pkg::*;
#(
  parameter int unsigned ADDR_SEL_W  = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [ADDR_SEL_W-1:0] addr_sel_i,
  output logic                  sda_pull_o,
  output logic                  wr_valid_o,
  output logic [IDX_W-1:0]      wr_index_o,
  output logic [DATA_W-1:0]     wr_data_o
);
  localparam int unsigned ADDR_W    = 3 + ADDR_SEL_W;
  localparam int unsigned BIT_CNT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(DATA_W);

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       start_w, stop_w, scl_rise_w, scl_fall_w;

  i2c_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w)
  );

  phase_e                 phase_q;
  logic [BIT_CNT_W-1:0]   bit_cnt_q;
  logic [DATA_W-1:0]      shift_q;
  logic                   ack_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   wr_valid_q;
  logic [IDX_W-1:0]       wr_index_q;
  logic [DATA_W-1:0]      wr_data_q;

  logic rx_active, byte_done, addr_hit;

  assign rx_active = (phase_q == PH_ADDR) || (phase_q == PH_PTR) || (phase_q == PH_DATA);
  assign byte_done = (bit_cnt_q == LAST_BIT);
  // address bits above R/W, R/W must be 0
  assign addr_hit  = (shift_q[DATA_W-1 -: ADDR_W] == {ADDR_PREFIX, addr_sel_i}) && !shift_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      ack_q      <= 1'b0;
      idx_q      <= '0;
      wr_valid_q <= 1'b0;
      wr_index_q <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      if (start_w) begin
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (stop_w) begin
        phase_q   <= PH_IDLE;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (scl_rise_w && rx_active && !ack_q && !byte_done) begin
        shift_q   <= {shift_q[DATA_W-2:0], sda_s};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end else if (scl_fall_w) begin
        if (ack_q) begin
          // end of ack slot: release and start next byte
          ack_q     <= 1'b0;
          bit_cnt_q <= '0;
        end else if (byte_done) begin
          unique case (phase_q)
            PH_ADDR: begin
              if (addr_hit) begin
                ack_q   <= 1'b1;
                phase_q <= PH_PTR;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            PH_PTR: begin
              ack_q   <= 1'b1;
              idx_q   <= IDX_W'(shift_q);
              phase_q <= PH_DATA;
            end
            PH_DATA: begin
              ack_q      <= 1'b1;
              wr_valid_q <= 1'b1;
              wr_index_q <= idx_q;
              wr_data_q  <= shift_q;
              idx_q      <= idx_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_pull_o = ack_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_index_o = wr_index_q;
  assign wr_data_o  = wr_data_q;
endmodule

// File: rtl/i2c_reg_wr_checker.sv
module i2c_reg_wr_checker #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             scl_fall_i,
  input logic             sda_pull_o,
  input logic             wr_valid_o,
  input logic [IDX_W-1:0] wr_index_o
);
  logic             seen_q;
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (start_i) begin
      seen_q <= 1'b0;
    end else if (wr_valid_o) begin
      seen_q <= 1'b1;
      last_q <= wr_index_o;
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r5_strobe_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> sda_pull_o);

  a_r5_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && seen_q) |-> (wr_index_o == IDX_W'(last_q + 1'b1)));

  a_r5_strobe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> $past(scl_fall_i));

  a_r9_pull_moves_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> $past(scl_fall_i || start_i || stop_i));

  a_r1_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pull_o);
endmodule

bind i2c_reg_wr_target i2c_reg_wr_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_w),
  .stop_i    (stop_w),
  .scl_fall_i(scl_fall_w),
  .sda_pull_o(sda_pull_o),
  .wr_valid_o(wr_valid_o),
  .wr_index_o(wr_index_o)
);

// File: tb/tb_i2c_reg_wr_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_wr_target;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] sel = 4'h5;
  logic       sda_bus;
  logic       sda_pull;
  logic       wr_valid;
  logic [7:0] wr_index, wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_reg_wr_target dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .addr_sel_i(sel),
    .sda_pull_o(sda_pull),
    .wr_valid_o(wr_valid),
    .wr_index_o(wr_index),
    .wr_data_o (wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wr(input logic [7:0] idx, input logic [7:0] dat);
    exp_q.push_back({idx, dat});
  endtask

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_ni && wr_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", {wr_index, wr_data}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({wr_index, wr_data} == e, "R5 strobe index/data", {wr_index, wr_data}, e);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(HP);
    scl_m = 1'b1; wait_clk(HP);
    sda_m = 1'b0; wait_clk(HP);
    scl_m = 1'b0; wait_clk(HP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HP);
    scl_m = 1'b1; wait_clk(HP);
    sda_m = 1'b1; wait_clk(HP);
    chk(sda_pull == 1'b0, "R1 released after stop", sda_pull, 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(HP);
      scl_m = 1'b1; wait_clk(HP/2);
      chk(sda_pull == 1'b0, "R9 no pull during data bit", sda_pull, 0);
      wait_clk(HP/2);
      scl_m = 1'b0;
      if (i == 0) begin
        wait_clk(2);
        chk(sda_pull == 1'b0, "R10 pull not before third edge", sda_pull, 0);
        wait_clk(1);
        chk(sda_pull == exp_ack, "R10 pull on third edge", sda_pull, exp_ack);
        wait_clk(HP-3);
      end else begin
        wait_clk(HP);
      end
    end
    sda_m = 1'b1; wait_clk(HP);
    scl_m = 1'b1; wait_clk(HP/2);
    chk(~sda_bus == exp_ack, req, ~sda_bus, exp_ack);
    wait_clk(HP/2);
    scl_m = 1'b0; wait_clk(HP);
  endtask

  function automatic logic [7:0] adr(input logic [3:0] s, input bit rd);
    return {3'b110, s, rd};
  endfunction

  task automatic drain(input string req);
    wait_clk(4);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    wait_clk(3);
    chk(sda_pull == 1'b0 && wr_valid == 1'b0, "R1 reset state", {sda_pull, wr_valid}, 0);
    rst_ni = 1'b1;
    wait_clk(4);

    // basic write: pointer then two data bytes
    bus_start();
    send_byte(adr(sel, 1'b0), 1'b1, "R2 R3 address ack");
    send_byte(8'h10, 1'b1, "R4 pointer ack");
    expect_wr(8'h10, 8'hA5);
    send_byte(8'hA5, 1'b1, "R5 data ack");
    expect_wr(8'h11, 8'h3C);
    send_byte(8'h3C, 1'b1, "R5 data ack");
    bus_stop();
    drain("R5 all writes seen");

    // wrong address: no ack, no strobes
    bus_start();
    send_byte(adr(4'hA, 1'b0), 1'b0, "R6 mismatch no ack");
    send_byte(8'h20, 1'b0, "R6 ignored byte");
    send_byte(8'h77, 1'b0, "R6 ignored byte");
    bus_stop();
    drain("R6 no strobes");

    // read request to own address refused
    bus_start();
    send_byte(adr(sel, 1'b1), 1'b0, "R7 read not acked");
    send_byte(8'h55, 1'b0, "R7 byte ignored");
    bus_stop();
    drain("R7 no strobes");

    // stop right after pointer: no strobe
    bus_start();
    send_byte(adr(sel, 1'b0), 1'b1, "R2 address ack");
    send_byte(8'h33, 1'b1, "R4 pointer ack");
    bus_stop();
    drain("R4 pointer makes no strobe");

    // repeated start mid-data reloads pointer
    bus_start();
    send_byte(adr(sel, 1'b0), 1'b1, "R8 address ack");
    send_byte(8'h40, 1'b1, "R8 pointer ack");
    expect_wr(8'h40, 8'h11);
    send_byte(8'h11, 1'b1, "R8 data ack");
    bus_start();
    send_byte(adr(sel, 1'b0), 1'b1, "R8 address after restart");
    send_byte(8'h80, 1'b1, "R8 new pointer ack");
    expect_wr(8'h80, 8'h22);
    send_byte(8'h22, 1'b1, "R8 data ack");
    expect_wr(8'h81, 8'h33);
    send_byte(8'h33, 1'b1, "R8 data ack");
    bus_stop();
    drain("R8 writes after restart");

    // index wrap-around
    bus_start();
    send_byte(adr(sel, 1'b0), 1'b1, "R5 address ack");
    send_byte(8'hFF, 1'b1, "R5 pointer ack");
    expect_wr(8'hFF, 8'h01);
    send_byte(8'h01, 1'b1, "R5 data ack");
    expect_wr(8'h00, 8'h02);
    send_byte(8'h02, 1'b1, "R5 wrap data ack");
    bus_stop();
    drain("R5 wrap writes");

    // change of select input moves the address
    sel = 4'h9;
    wait_clk(4);
    bus_start();
    send_byte(adr(4'h5, 1'b0), 1'b0, "R2 old address refused");
    bus_stop();
    bus_start();
    send_byte(adr(4'h9, 1'b0), 1'b1, "R2 new address ack");
    send_byte(8'h07, 1'b1, "R4 pointer ack");
    expect_wr(8'h07, 8'hC3);
    send_byte(8'hC3, 1'b1, "R5 data ack");
    bus_stop();
    drain("R2 write with new select");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule